// File: doc/BRIEF.md
# Cache Maintenance Walker

This block sequences maintenance operations over the valid and dirty bits of a small set-associative write-back data cache. A command either sweeps every line of the cache or touches one line chosen by way and set. For each line, the block can write a dirty line back to the next level, drop the line, or do both. The tag/state array lives outside the block. The walker presents a line index, reads that line's valid and dirty bits in the same cycle, and returns per-line clear strobes that the array applies at the next clock edge.

Write-back requests leave through a ready/valid port that carries the set and way of the line. The walker waits on a dirty line until that request is taken. Software-visible sequencing sits in front of the block: it raises a command with a 3-bit opcode and a 32-bit way/set operand, watches `busy`, and waits for the one-cycle `done` pulse.

Top module: `cache_maint_walker`

## Requirements
- R1: While reset is asserted and in the first cycle after it, `busy`, `done`, `wb_valid`, `ln_clr_valid` and `ln_clr_dirty` are 0 and `cmd_ready` is 1.
- R2: A command is taken on a clock edge where `cmd_valid` and `cmd_ready` are both 1. `cmd_ready` is 0 whenever `busy` is 1. A command raised while busy has no effect on the array and is not started later.
- R3: A sweep visits lines in ascending set order, and within a set in ascending way order. The first line (set 0, way 0) is presented in the cycle after acceptance. The walk advances one line per cycle whenever no write-back is waiting.
- R4: In clean mode, a line that is both valid and dirty raises `wb_valid` with its own set and way on `wb_set`/`wb_way`. Its dirty bit is cleared in the cycle the request is taken, and its valid bit is kept. Invalid or clean lines produce no request.
- R5: In invalidate mode, every visited line has its valid bit and its dirty bit cleared, and no write-back is requested.
- R6: In clean-and-invalidate mode, a valid dirty line is written back first. Its valid and dirty bits are cleared in the same cycle the request is taken. Every other visited line is invalidated without a request.
- R7: While `wb_valid` is 1 and `wb_ready` is 0, the request and its set and way stay unchanged, and no clear strobe is raised.
- R8: For a single-line command, the way is taken from the top operand bits (bit 31 for 2 ways, bits 31:30 for 4 ways). The set is taken from the bits starting at bit 6, which is 64-byte lines (bits 12:6 for the default 128 sets). All other operand bits are ignored.
- R9: After the last line of a command retires, `done` is 1 for exactly one cycle with `busy` still 1. `busy` is 0 in the following cycle.
- R10: Opcode bit 2 selects a single line (1) or a sweep (0). Opcode bits 1:0 select the mode: 0 clean, 1 invalidate, 2 clean-and-invalidate, 3 no action. In mode 3 the walk still runs and completes but changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid | input | 1 | Command request |
| cmd_ready | output | 1 | Command can be taken (walker idle) |
| cmd_op | input | 3 | Opcode: bit 2 single line, bits 1:0 mode |
| cmd_arg | input | 32 | Way/set operand for single-line commands |
| ln_set | output | SET_W (7) | Set of the line being visited |
| ln_way | output | WAY_W (1) | Way of the line being visited |
| ln_valid | input | 1 | Valid bit of the visited line |
| ln_dirty | input | 1 | Dirty bit of the visited line |
| ln_clr_valid | output | 1 | Clear the valid bit of the visited line at the next edge |
| ln_clr_dirty | output | 1 | Clear the dirty bit of the visited line at the next edge |
| wb_valid | output | 1 | Write-back request |
| wb_ready | input | 1 | Write-back request taken |
| wb_set | output | SET_W (7) | Set of the line to write back |
| wb_way | output | WAY_W (1) | Way of the line to write back |
| busy | output | 1 | A command is in progress |
| done | output | 1 | One-cycle pulse at command completion |

## Verification
The hardest situation to reach is a stalled write-back in the middle of a clean-and-invalidate sweep. In that case the line's clears must wait while the request stays frozen, and the walk must then resume at the next line with no skipped or repeated index. The bench gets there by throttling `wb_ready` to one cycle in three across a full sweep of a mixed valid/dirty pattern. It also holds `wb_ready` low for several cycles in front of a single-line clean whose operand carries garbage in every unused bit. A second command raised during a sweep checks that a busy walker ignores new requests.

// File: rtl/cmw_pkg.sv
package cmw_pkg;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_WALK = 2'd1,
    ST_FIN  = 2'd2
  } walk_state_e;

  typedef enum logic [1:0] {
    MD_CLEAN = 2'd0,
    MD_INV   = 2'd1,
    MD_BOTH  = 2'd2,
    MD_NOP   = 2'd3
  } maint_mode_e;

  function automatic logic mode_cleans(maint_mode_e m);
    return (m == MD_CLEAN) || (m == MD_BOTH);
  endfunction

  function automatic logic mode_drops(maint_mode_e m);
    return (m == MD_INV) || (m == MD_BOTH);
  endfunction

endpackage

// File: rtl/cmw_cmd_decode.sv
module cmw_cmd_decode
  import cmw_pkg::*;
#(
  parameter int unsigned WAY_W    = 1,
  parameter int unsigned SET_W    = 7,
  parameter int unsigned LINE_OFS = 6
) (
  input  logic [2:0]       op,
  input  logic [31:0]      arg,
  output maint_mode_e      mode,
  output logic             single,
  output logic [SET_W-1:0] set_idx,
  output logic [WAY_W-1:0] way_idx
);

  localparam int unsigned WAY_LSB  = 32 - WAY_W;
  localparam logic [31:0] WAY_MASK = {32{1'b1}} << WAY_LSB;
  localparam logic [31:0] SET_MASK = ((32'd1 << SET_W) - 32'd1) << LINE_OFS;

  logic arg_unused;

  assign mode       = maint_mode_e'(op[1:0]);
  assign single     = op[2];
  assign way_idx    = arg[WAY_LSB +: WAY_W];
  assign set_idx    = arg[LINE_OFS +: SET_W];
  // bits outside the way and set fields carry no meaning
  assign arg_unused = ^(arg & ~(WAY_MASK | SET_MASK));

endmodule

// File: rtl/cmw_line_ptr.sv
module cmw_line_ptr #(
  parameter int unsigned NUM_WAYS = 2,
  parameter int unsigned NUM_SETS = 128,
  parameter int unsigned WAY_W    = 1,
  parameter int unsigned SET_W    = 7
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [SET_W-1:0] load_set,
  input  logic [WAY_W-1:0] load_way,
  input  logic             adv,
  output logic [SET_W-1:0] set_q,
  output logic [WAY_W-1:0] way_q,
  output logic             last
);

  localparam logic [WAY_W-1:0] WAY_MAX = WAY_W'(NUM_WAYS - 1);
  localparam logic [SET_W-1:0] SET_MAX = SET_W'(NUM_SETS - 1);

  logic [SET_W-1:0] set_d;
  logic [WAY_W-1:0] way_d;
  logic             ptr_en;

  always_comb begin
    ptr_en = load | adv;
    set_d  = set_q;
    way_d  = way_q;
    if (load) begin
      set_d = load_set;
      way_d = load_way;
    end else if (adv) begin
      if (way_q == WAY_MAX) begin
        way_d = '0;
        set_d = set_q + SET_W'(1);
      end else begin
        way_d = way_q + WAY_W'(1);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      set_q <= '0;
      way_q <= '0;
    end else if (ptr_en) begin
      set_q <= set_d;
      way_q <= way_d;
    end
  end

  assign last = (way_q == WAY_MAX) && (set_q == SET_MAX);

endmodule

// File: rtl/cmw_line_action.sv
module cmw_line_action
  import cmw_pkg::*;
(
  input  logic        active,
  input  maint_mode_e mode,
  input  logic        ln_valid,
  input  logic        ln_dirty,
  input  logic        wb_ready,
  output logic        wb_req,
  output logic        retire,
  output logic        clr_valid,
  output logic        clr_dirty
);

  logic cleans;
  logic drops;

  always_comb begin
    cleans    = mode_cleans(mode);
    drops     = mode_drops(mode);
    wb_req    = active & cleans & ln_valid & ln_dirty;
    retire    = active & (~wb_req | wb_ready);
    clr_valid = retire & drops & ln_valid;
    clr_dirty = retire & ((drops & ln_dirty) | wb_req);
  end

endmodule

// File: rtl/cache_maint_walker.sv
module cache_maint_walker
  import cmw_pkg::*;
#(
  parameter int unsigned NUM_WAYS   = 2,
  parameter int unsigned NUM_SETS   = 128,
  parameter int unsigned LINE_BYTES = 64,
  localparam int unsigned WAY_W     = $clog2(NUM_WAYS),
  localparam int unsigned SET_W     = $clog2(NUM_SETS),
  localparam int unsigned LINE_OFS  = $clog2(LINE_BYTES)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cmd_valid,
  output logic             cmd_ready,
  input  logic [2:0]       cmd_op,
  input  logic [31:0]      cmd_arg,
  output logic [SET_W-1:0] ln_set,
  output logic [WAY_W-1:0] ln_way,
  input  logic             ln_valid,
  input  logic             ln_dirty,
  output logic             ln_clr_valid,
  output logic             ln_clr_dirty,
  output logic             wb_valid,
  input  logic             wb_ready,
  output logic [SET_W-1:0] wb_set,
  output logic [WAY_W-1:0] wb_way,
  output logic             busy,
  output logic             done
);

  walk_state_e      state_q, state_d;
  maint_mode_e      mode_q, mode_d;
  logic             single_q, single_d;
  maint_mode_e      dec_mode;
  logic             dec_single;
  logic [SET_W-1:0] dec_set, ptr_set, load_set;
  logic [WAY_W-1:0] dec_way, ptr_way, load_way;
  logic             ptr_last, cmd_fire, walk_end, retire, wb_req, adv;

  cmw_cmd_decode #(.WAY_W(WAY_W), .SET_W(SET_W), .LINE_OFS(LINE_OFS)) u_dec (
    .op(cmd_op), .arg(cmd_arg), .mode(dec_mode), .single(dec_single),
    .set_idx(dec_set), .way_idx(dec_way)
  );

  assign cmd_fire = cmd_valid && (state_q == ST_IDLE);
  assign walk_end = single_q | ptr_last;
  assign adv      = retire & ~walk_end;
  assign load_set = dec_single ? dec_set : '0;
  assign load_way = dec_single ? dec_way : '0;

  cmw_line_ptr #(.NUM_WAYS(NUM_WAYS), .NUM_SETS(NUM_SETS), .WAY_W(WAY_W), .SET_W(SET_W)) u_ptr (
    .clk(clk), .rst_n(rst_n), .load(cmd_fire), .load_set(load_set), .load_way(load_way),
    .adv(adv), .set_q(ptr_set), .way_q(ptr_way), .last(ptr_last)
  );

  cmw_line_action u_act (
    .active(state_q == ST_WALK), .mode(mode_q), .ln_valid(ln_valid), .ln_dirty(ln_dirty),
    .wb_ready(wb_ready), .wb_req(wb_req), .retire(retire),
    .clr_valid(ln_clr_valid), .clr_dirty(ln_clr_dirty)
  );

  always_comb begin
    state_d  = state_q;
    mode_d   = mode_q;
    single_d = single_q;
    case (state_q)
      ST_IDLE: if (cmd_fire) begin
        state_d  = ST_WALK;
        mode_d   = dec_mode;
        single_d = dec_single;
      end
      ST_WALK: if (retire && walk_end) state_d = ST_FIN;
      ST_FIN:  state_d = ST_IDLE;
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q  <= ST_IDLE;
      mode_q   <= MD_NOP;
      single_q <= 1'b0;
    end else begin
      state_q <= state_d;
      if (cmd_fire) begin
        mode_q   <= mode_d;
        single_q <= single_d;
      end
    end
  end

  assign cmd_ready = (state_q == ST_IDLE);
  assign busy      = (state_q != ST_IDLE);
  assign done      = (state_q == ST_FIN);
  assign ln_set    = ptr_set;
  assign ln_way    = ptr_way;
  assign wb_valid  = wb_req;
  assign wb_set    = ptr_set;
  assign wb_way    = ptr_way;

endmodule

// File: rtl/cache_maint_walker_chk.sv
module cache_maint_walker_chk #(
  parameter int unsigned SET_W = 7,
  parameter int unsigned WAY_W = 1
) (
  input logic             clk,
  input logic             rst_n,
  input logic             cmd_valid,
  input logic             cmd_ready,
  input logic             ln_clr_valid,
  input logic             ln_clr_dirty,
  input logic             wb_valid,
  input logic             wb_ready,
  input logic [SET_W-1:0] wb_set,
  input logic [WAY_W-1:0] wb_way,
  input logic             busy,
  input logic             done
);

  a_r7_request_held: assert property (@(posedge clk) disable iff (!rst_n)
    (wb_valid && !wb_ready) |=> (wb_valid && $stable(wb_set) && $stable(wb_way)));

  a_r7_no_clear_while_stalled: assert property (@(posedge clk) disable iff (!rst_n)
    (wb_valid && !wb_ready) |-> (!ln_clr_valid && !ln_clr_dirty));

  a_r4_taken_clears_dirty: assert property (@(posedge clk) disable iff (!rst_n)
    (wb_valid && wb_ready) |-> ln_clr_dirty);

  a_r9_done_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> (!done && !busy));

  a_r9_done_inside_busy: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> busy);

  a_r2_start_needs_command: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(cmd_valid && cmd_ready));

endmodule

bind cache_maint_walker cache_maint_walker_chk #(.SET_W(SET_W), .WAY_W(WAY_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
  .ln_clr_valid(ln_clr_valid), .ln_clr_dirty(ln_clr_dirty), .wb_valid(wb_valid),
  .wb_ready(wb_ready), .wb_set(wb_set), .wb_way(wb_way), .busy(busy), .done(done)
);

// File: tb/cache_maint_walker_test.sv
`timescale 1ns/100ps
module cache_maint_walker_test;
  localparam int WAYS = 2;
  localparam int SETS = 128;
  localparam int LINES = WAYS * SETS;

  logic clk = 1'b0;
  logic rst_n;
  logic cmd_valid, cmd_ready;
  logic [2:0] cmd_op;
  logic [31:0] cmd_arg;
  logic [6:0] ln_set, wb_set;
  logic [0:0] ln_way, wb_way;
  logic ln_valid, ln_dirty, ln_clr_valid, ln_clr_dirty;
  logic wb_valid, wb_ready, busy, done;

  bit arr_v[LINES];
  bit arr_d[LINES];
  bit snap_v[LINES];
  bit snap_d[LINES];
  int cur;
  int checks = 0, errors = 0, wb_cnt = 0, cyc = 0, wd = 0;
  int rdy_mode = 0, rdy_hold = 0;
  bit fill_req = 0;
  int fill_seed = 0, force_a = -1, force_b = -1;
  int m_st = 0, m_mode = 3, m_idx = 0, m_end = 0;
  int n_st = 0, n_mode = 3, n_idx = 0, n_end = 0;

  always #2.5 clk = ~clk;

  cache_maint_walker uut (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
    .cmd_op(cmd_op), .cmd_arg(cmd_arg), .ln_set(ln_set), .ln_way(ln_way),
    .ln_valid(ln_valid), .ln_dirty(ln_dirty), .ln_clr_valid(ln_clr_valid),
    .ln_clr_dirty(ln_clr_dirty), .wb_valid(wb_valid), .wb_ready(wb_ready),
    .wb_set(wb_set), .wb_way(wb_way), .busy(busy), .done(done)
  );

  always_comb cur = int'(ln_set) * WAYS + int'(ln_way);
  assign ln_valid = arr_v[cur];
  assign ln_dirty = arr_d[cur];

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d (t=%0t)", req, what, act, exp, $time);
    end
  endtask

  // write-back acceptance pattern
  always @(negedge clk) begin
    cyc++;
    if (rdy_hold > 0) begin
      rdy_hold--;
      wb_ready = 1'b0;
    end else begin
      wb_ready = (rdy_mode == 0) || (cyc % 3 == 0);
    end
  end

  // reference model, compared every cycle
  always @(negedge clk) begin
    #1;
    if (rst_n) begin
      bit v, d, cl, iv, wb, fire;
      int e_set, e_way;
      string stall_tag;
      v = 0; d = 0; wb = 0; fire = 0;
      cl = (m_mode == 0) || (m_mode == 2);
      iv = (m_mode == 1) || (m_mode == 2);
      chk(busy == (m_st != 0), "R9", "busy", busy, m_st != 0);
      chk(cmd_ready == (m_st == 0), "R2", "cmd_ready", cmd_ready, m_st == 0);
      chk(done == (m_st == 2), "R9", "done", done, m_st == 2);
      if (m_st == 1) begin
        e_set = m_idx / WAYS;
        e_way = m_idx % WAYS;
        chk(int'(ln_set) == e_set, "R3", "ln_set", int'(ln_set), e_set);
        chk(int'(ln_way) == e_way, "R3", "ln_way", int'(ln_way), e_way);
        v = arr_v[m_idx];
        d = arr_d[m_idx];
        wb = cl && v && d;
        fire = !wb || wb_ready;
        if (wb) begin
          chk(int'(wb_set) == e_set, "R4", "wb_set", int'(wb_set), e_set);
          chk(int'(wb_way) == e_way, "R4", "wb_way", int'(wb_way), e_way);
        end
      end
      stall_tag = (wb && !wb_ready) ? "R7" : "R5";
      chk(wb_valid == wb, "R4", "wb_valid", wb_valid, wb);
      chk(ln_clr_valid == (fire && iv && v), stall_tag, "ln_clr_valid", ln_clr_valid, fire && iv && v);
      stall_tag = (wb && !wb_ready) ? "R7" : "R6";
      chk(ln_clr_dirty == (fire && ((iv && d) || wb)), stall_tag, "ln_clr_dirty",
          ln_clr_dirty, fire && ((iv && d) || wb));
      n_st = m_st; n_mode = m_mode; n_idx = m_idx; n_end = m_end;
      case (m_st)
        0: if (cmd_valid) begin
          n_st = 1;
          n_mode = int'(cmd_op[1:0]);
          if (cmd_op[2]) begin
            n_idx = int'(cmd_arg[12:6]) * WAYS + int'(cmd_arg[31]);
            n_end = n_idx;
          end else begin
            n_idx = 0;
            n_end = LINES - 1;
          end
        end
        1: if (fire) begin
          if (m_idx == m_end) n_st = 2;
          else n_idx = m_idx + 1;
        end
        default: n_st = 0;
      endcase
    end
  end

  always @(posedge clk) begin
    if (!rst_n) begin
      m_st = 0;
      n_st = 0;
    end else begin
      m_st = n_st; m_mode = n_mode; m_idx = n_idx; m_end = n_end;
      if (ln_clr_valid) arr_v[cur] <= 1'b0;
      if (ln_clr_dirty) arr_d[cur] <= 1'b0;
      if (wb_valid && wb_ready) wb_cnt++;
    end
    if (fill_req) begin
      for (int i = 0; i < LINES; i++) begin
        arr_v[i] <= ((i * 7 + fill_seed) % 4) != 0;
        arr_d[i] <= ((i * 5 + fill_seed) % 3) == 0;
      end
      if (force_a >= 0) begin arr_v[force_a] <= 1'b1; arr_d[force_a] <= 1'b1; end
      if (force_b >= 0) begin arr_v[force_b] <= 1'b1; arr_d[force_b] <= 1'b1; end
    end
  end

  always @(posedge clk) begin
    wd++;
    if (wd > 150000) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual %0d cycles expected completion", wd);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  task automatic fill(input int seed, input int fa, input int fb);
    @(negedge clk);
    fill_seed = seed; force_a = fa; force_b = fb; fill_req = 1'b1;
    @(negedge clk);
    fill_req = 1'b0;
  endtask

  task automatic run(input logic [2:0] op, input logic [31:0] arg, input int lo, input int hi,
                     input string tag, input bit intrude);
    int mism, exp_wb, md;
    bit ev, ed;
    for (int i = 0; i < LINES; i++) begin snap_v[i] = arr_v[i]; snap_d[i] = arr_d[i]; end
    wb_cnt = 0;
    cmd_valid = 1'b1; cmd_op = op; cmd_arg = arg;
    @(negedge clk);
    cmd_valid = 1'b0;
    if (intrude) begin
      repeat (4) @(negedge clk);
      cmd_valid = 1'b1; cmd_op = 3'd1; cmd_arg = 32'h0;
      repeat (3) @(negedge clk);
      cmd_valid = 1'b0;
    end
    while (busy) @(negedge clk);
    @(negedge clk);
    md = int'(op[1:0]);
    mism = 0; exp_wb = 0;
    for (int i = 0; i < LINES; i++) begin
      ev = snap_v[i]; ed = snap_d[i];
      if (i >= lo && i <= hi) begin
        if ((md == 0 || md == 2) && ev && ed) exp_wb++;
        if (md == 0) ed = ed && !ev;
        if (md == 1 || md == 2) begin ev = 0; ed = 0; end
      end
      if (arr_v[i] != ev || arr_d[i] != ed) mism++;
    end
    chk(mism == 0, tag, "lines with wrong state", mism, 0);
    chk(wb_cnt == exp_wb, tag, "write-backs", wb_cnt, exp_wb);
  endtask

  initial begin
    rst_n = 1'b0; cmd_valid = 1'b0; cmd_op = 3'd0; cmd_arg = 32'h0;
    repeat (3) @(negedge clk);
    // R1: outputs in reset
    chk(busy == 0, "R1", "busy", busy, 0);
    chk(done == 0, "R1", "done", done, 0);
    chk(wb_valid == 0, "R1", "wb_valid", wb_valid, 0);
    chk(ln_clr_valid == 0 && ln_clr_dirty == 0, "R1", "clear strobes", ln_clr_valid | ln_clr_dirty, 0);
    chk(cmd_ready == 1, "R1", "cmd_ready", cmd_ready, 1);
    rst_n = 1'b1;
    @(negedge clk);
    chk(busy == 0 && cmd_ready == 1, "R1", "idle after release", busy, 0);

    fill(1, -1, -1);
    run(3'd0, 32'h0, 0, LINES - 1, "R4", 1'b0);        // clean sweep, R3 order
    fill(2, -1, -1);
    rdy_mode = 1;
    run(3'd2, 32'h0, 0, LINES - 1, "R6", 1'b0);        // throttled, R7 stalls
    rdy_mode = 0;
    fill(3, -1, -1);
    run(3'd1, 32'h0, 0, LINES - 1, "R5", 1'b0);
    fill(0, 155, -1);
    rdy_hold = 6;                                       // R7 long stall
    run(3'd4, 32'h8000_0000 | (32'd77 << 6) | 32'h2AAA_A000 | 32'h15, 155, 155, "R8", 1'b0);
    fill(4, 0, 255);
    run(3'd5, 32'h0000_003F, 0, 0, "R10", 1'b0);
    run(3'd6, 32'h8000_0000 | (32'd127 << 6), 255, 255, "R10", 1'b0);
    fill(5, -1, -1);
    run(3'd3, 32'h0, 0, LINES - 1, "R10", 1'b0);       // mode 3: no action
    fill(6, -1, -1);
    run(3'd0, 32'h0, 0, LINES - 1, "R2", 1'b1);        // command while busy ignored

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule